// File: doc/BRIEF.md
# Interrupt Priority Acceptance Unit

This unit decides, once per clock, whether the processor takes an interrupt. It does not save context or fetch the vector. Two kinds of request reach it:

- A bank of maskable request lines. Each line has its own programmed 3-bit priority.
- A software interrupt request, which carries a 6-bit interrupt number.

It also reads three fields of the current processor status word: the interrupt-enable flag, the stack-select flag and the 3-bit processor priority level (levels 0 to 7).

When a request is taken, the unit does four things:

- It raises a one-cycle accept pulse.
- It reports the interrupt number and whether the request came from software.
- It computes the address of the vector entry. The entry is four bytes wide and sits in a table whose 20-bit base comes from the processor.
- It presents the updated status fields for the core to write back.

When nothing is taken, the status outputs repeat the incoming status fields one cycle later. The core can therefore always write the outputs back.

Every output is registered, so results appear one clock after the inputs that cause them. A pulse is followed by a one-cycle pause during which no request is taken. This pause gives the core time to commit the new status before the next decision.

Top module: `irq_accept_unit`

## Requirements
- R1: While `rst` is high, at the next clock edge every output becomes 0, whatever the inputs are.
- R2: A maskable line `i` is taken only when `ien_i` is 1 and its priority (`prio_i[3*i+2:3*i]`) is strictly greater than `ipl_i`.
- R3: A line whose programmed priority is 0 is never taken, even when `ipl_i` is 0 and `ien_i` is 1.
- R4: Among the eligible maskable lines, the one with the highest priority wins. When priorities tie, the lowest line index wins.
- R5: A software request is taken whatever the values of `ien_i` and `ipl_i`. If a maskable request is also eligible in the same cycle, the software request wins; this is shown by `sw_taken_o` = 1 and `num_o` = `sw_num_i`.
- R6: When a request is taken, `ien_o` is 0. When nothing is taken, `ien_o`, `stk_o` and `ipl_o` equal the `ien_i`, `stk_i` and `ipl_i` values of the previous cycle.
- R7: `stk_o` is 0 after a maskable line is taken, and 0 after a software interrupt numbered 0 to 31 is taken. After a software interrupt numbered 32 to 63 is taken, `stk_o` keeps the previous `stk_i`.
- R8: When a maskable line is taken, `ipl_o` is set to that line's priority. When a software interrupt is taken, `ipl_o` keeps the previous `ipl_i`.
- R9: When a maskable line is taken, its interrupt number is its line index (plus `HW_NUM_BASE`, which defaults to 0). `vec_o` = `tbl_base_i` + 4 × number, wrapped to 20 bits. `num_o` and `vec_o` hold their last values while no request is taken.
- R10: `take_o` is never high in two consecutive cycles. Requests present in the cycle that follows a pulse are ignored.
- R11: The outputs follow their inputs one clock later. Between clock edges the outputs do not change when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NUM_SRC | Maskable request lines |
| prio_i | input | NUM_SRC*3 | Programmed priority of each line, 3 bits per line |
| sw_req_i | input | 1 | Software interrupt request |
| sw_num_i | input | 6 | Software interrupt number |
| ien_i | input | 1 | Current interrupt-enable flag |
| stk_i | input | 1 | Current stack-select flag |
| ipl_i | input | 3 | Current processor priority level |
| tbl_base_i | input | 20 | Base address of the vector table |
| take_o | output | 1 | Accept pulse, one cycle wide |
| sw_taken_o | output | 1 | The accepted request came from software |
| num_o | output | 6 | Interrupt number of the last accepted request |
| vec_o | output | 20 | Vector entry address of the last accepted request |
| ien_o | output | 1 | Updated interrupt-enable flag |
| stk_o | output | 1 | Updated stack-select flag |
| ipl_o | output | 3 | Updated processor priority level |

## Verification
Two events can fall in the same cycle: a software request, and a maskable line that would be eligible on its own merits. The bench provokes this by holding a priority-7 line high with `ipl_i` at 0 while it sweeps every software number, with `ien_i` both low and high. The result is judged on four outputs:

- `sw_taken_o` must be 1.
- `num_o` must be the software number.
- `ipl_o` must be left unchanged.
- `stk_o` must be cleared below 32 and kept from 32 upward.

A second collision is a request held through the pause after a pulse; the bench checks that it is taken only two cycles after the first pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int PRIO_W       = 3;
    localparam int ADDR_W       = 20;
    localparam int NUM_W        = 6;
    localparam int STK_SW_LIMIT = 32;
    localparam int ENTRY_SHIFT  = 2;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [NUM_W-1:0]  num_t;

    typedef struct packed {
        logic  ien;
        logic  stk;
        prio_t ipl;
    } status_t;

    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_HW   = 2'd1,
        TAKE_SW   = 2'd2
    } take_e;

    function automatic addr_t entry_addr(addr_t base, num_t n);
        return base + (addr_t'(n) << ENTRY_SHIFT);
    endfunction

    function automatic logic sw_clears_stack(num_t n);
        return (int'(n) < STK_SW_LIMIT);
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 15,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          idx_o,
    output prio_t                     prio_o
);

    // Ascending scan with a strict compare: a later line of equal priority
    // cannot displace an earlier one, and priority 0 never beats the seed.
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(i);
                prio_o = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_decide.sv
module irq_decide
    import irq_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int HW_NUM_BASE = 0
) (
    input  logic             lock_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    input  prio_t            prio_i,
    input  logic             sw_req_i,
    input  num_t             sw_num_i,
    input  status_t          cur_i,
    output take_e            kind_o,
    output num_t             num_o,
    output status_t          nxt_o
);

    logic hw_ok;

    assign hw_ok = hit_i && cur_i.ien && (prio_i > cur_i.ipl);

    always_comb begin
        kind_o = TAKE_NONE;
        if (!lock_i) begin
            if (sw_req_i)   kind_o = TAKE_SW;
            else if (hw_ok) kind_o = TAKE_HW;
        end
    end

    always_comb begin
        nxt_o = cur_i;
        num_o = '0;
        unique case (kind_o)
            TAKE_SW: begin
                num_o     = sw_num_i;
                nxt_o.ien = 1'b0;
                if (sw_clears_stack(sw_num_i)) nxt_o.stk = 1'b0;
            end
            TAKE_HW: begin
                num_o     = num_t'(HW_NUM_BASE) + num_t'(idx_i);
                nxt_o.ien = 1'b0;
                nxt_o.stk = 1'b0;
                nxt_o.ipl = prio_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
    import irq_pkg::*;
(
    input  addr_t base_i,
    input  num_t  num_i,
    output addr_t vec_o
);

    assign vec_o = entry_addr(base_i, num_i);

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter int NUM_SRC     = 15,
    parameter int HW_NUM_BASE = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic                      sw_req_i,
    input  logic [NUM_W-1:0]          sw_num_i,
    input  logic                      ien_i,
    input  logic                      stk_i,
    input  logic [PRIO_W-1:0]         ipl_i,
    input  logic [ADDR_W-1:0]         tbl_base_i,
    output logic                      take_o,
    output logic                      sw_taken_o,
    output logic [NUM_W-1:0]          num_o,
    output logic [ADDR_W-1:0]         vec_o,
    output logic                      ien_o,
    output logic                      stk_o,
    output logic [PRIO_W-1:0]         ipl_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic             win_hit;
    logic [IDX_W-1:0] win_idx;
    prio_t            win_prio;
    take_e            kind;
    num_t             next_num;
    addr_t            next_vec;
    status_t          cur_st;
    status_t          next_st;
    status_t          st_q;

    assign cur_st = '{ien: ien_i, stk: stk_i, ipl: ipl_i};

    irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
        .req_i  (req_i),
        .prio_i (prio_i),
        .hit_o  (win_hit),
        .idx_o  (win_idx),
        .prio_o (win_prio)
    );

    irq_decide #(.IDX_W(IDX_W), .HW_NUM_BASE(HW_NUM_BASE)) dec_i (
        .lock_i   (take_o),
        .hit_i    (win_hit),
        .idx_i    (win_idx),
        .prio_i   (win_prio),
        .sw_req_i (sw_req_i),
        .sw_num_i (sw_num_i),
        .cur_i    (cur_st),
        .kind_o   (kind),
        .num_o    (next_num),
        .nxt_o    (next_st)
    );

    irq_vec_gen vec_i (
        .base_i (tbl_base_i),
        .num_i  (next_num),
        .vec_o  (next_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            sw_taken_o <= 1'b0;
            num_o      <= '0;
            vec_o      <= '0;
            st_q       <= '0;
        end else begin
            take_o     <= (kind != TAKE_NONE);
            sw_taken_o <= (kind == TAKE_SW);
            st_q       <= next_st;
            if (kind != TAKE_NONE) begin
                num_o <= next_num;
                vec_o <= next_vec;
            end
        end
    end

    assign ien_o = st_q.ien;
    assign stk_o = st_q.stk;
    assign ipl_o = st_q.ipl;

    // R10: the pulse is never followed by another pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    // R6: taking any request drops the enable flag
    a_r6_ien_cleared: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !ien_o);

    // R2: a maskable take needs enable and a strictly higher priority
    a_r2_hw_gate: assert property (@(posedge clk) disable iff (rst)
        (take_o && !sw_taken_o && !$past(rst)) |-> ($past(ien_i) && (ipl_o > $past(ipl_i))));

    // R7: a maskable take always selects the interrupt stack
    a_r7_hw_stack: assert property (@(posedge clk) disable iff (rst)
        (take_o && !sw_taken_o) |-> !stk_o);

    // R8: a software take keeps the level
    a_r8_sw_level: assert property (@(posedge clk) disable iff (rst)
        (take_o && sw_taken_o && !$past(rst)) |-> (ipl_o == $past(ipl_i)));

    // R5: an unlocked software request is always taken as software
    a_r5_sw_taken: assert property (@(posedge clk) disable iff (rst)
        ($past(sw_req_i) && !$past(take_o) && !$past(rst)) |-> (take_o && sw_taken_o));

    // R9: vector entries stay 4-byte aligned relative to the base
    a_r9_vec_align: assert property (@(posedge clk) disable iff (rst)
        (take_o && !$past(rst)) |-> (vec_o[1:0] == $past(tbl_base_i[1:0])));

endmodule

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   req = '0;
    logic [NSRC*3-1:0] prio = '0;
    logic              sw_req = 1'b0;
    logic [5:0]        sw_num = '0;
    logic              ien = 1'b0;
    logic              stk = 1'b0;
    logic [2:0]        ipl = '0;
    logic [19:0]       base = '0;

    logic        take_o, sw_taken_o, ien_o, stk_o;
    logic [5:0]  num_o;
    logic [19:0] vec_o;
    logic [2:0]  ipl_o;

    logic        e_take, e_sw, e_ien, e_stk;
    logic [5:0]  e_num;
    logic [19:0] e_vec;
    logic [2:0]  e_ipl;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_accept_unit #(.NUM_SRC(NSRC)) dut_i (
        .clk(clk), .rst(rst), .req_i(req), .prio_i(prio),
        .sw_req_i(sw_req), .sw_num_i(sw_num), .ien_i(ien), .stk_i(stk),
        .ipl_i(ipl), .tbl_base_i(base), .take_o(take_o),
        .sw_taken_o(sw_taken_o), .num_o(num_o), .vec_o(vec_o),
        .ien_o(ien_o), .stk_o(stk_o), .ipl_o(ipl_o)
    );

    function automatic logic [31:0] next_rng(logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Expected next state, from the requirements
    task automatic predict();
        logic lock = e_take;
        int   best = 0;
        int   wi   = -1;
        for (int i = 0; i < NSRC; i++)
            if (req[i] && int'(prio[i*3 +: 3]) > best) begin
                best = int'(prio[i*3 +: 3]);
                wi   = i;
            end
        e_ien = ien; e_stk = stk; e_ipl = ipl;
        e_take = 1'b0; e_sw = 1'b0;
        if (!lock && sw_req) begin
            e_take = 1'b1; e_sw = 1'b1; e_num = sw_num;
            e_vec  = base + 20'(int'(sw_num) * 4);
            e_ien  = 1'b0;
            if (sw_num < 6'd32) e_stk = 1'b0;
        end else if (!lock && wi >= 0 && ien && best > int'(ipl)) begin
            e_take = 1'b1; e_num = 6'(wi);
            e_vec  = base + 20'(wi * 4);
            e_ien  = 1'b0; e_stk = 1'b0; e_ipl = 3'(best);
        end
    endtask

    task automatic compare(input string tag);
        tests++;
        if ({take_o, sw_taken_o, num_o, vec_o, ien_o, stk_o, ipl_o} !==
            {e_take, e_sw, e_num, e_vec, e_ien, e_stk, e_ipl}) begin
            fails++;
            $display("FAIL %s: got take=%0b sw=%0b num=%0d vec=%h ien=%0b stk=%0b ipl=%0d, exp take=%0b sw=%0b num=%0d vec=%h ien=%0b stk=%0b ipl=%0d",
                tag, take_o, sw_taken_o, num_o, vec_o, ien_o, stk_o, ipl_o,
                e_take, e_sw, e_num, e_vec, e_ien, e_stk, e_ipl);
        end
    endtask

    task automatic step(input string tag);
        predict();
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare(tag);
    endtask

    task automatic idle();
        req = '0; sw_req = 1'b0;
        step("R6 idle copy");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; tests++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        // R1: reset with busy inputs
        ien = 1; ipl = 3'd5; stk = 1; req = '1; prio = '1; sw_req = 1;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        e_take = 0; e_sw = 0; e_num = 0; e_vec = 0; e_ien = 0; e_stk = 0; e_ipl = 0;
        compare("R1 reset");
        rst = 0; req = '0; sw_req = 0; prio = '0;
        idle();

        // R2 R3 R8 R9: single line, every priority, level and enable
        base = 20'h3A5C4; stk = 1;
        for (int s = 0; s < NSRC; s++)
            for (int p = 0; p < 8; p++)
                for (int l = 0; l < 8; l++)
                    for (int e = 0; e < 2; e++) begin
                        req = '0; prio = '0;
                        req[s] = 1'b1; prio[s*3 +: 3] = 3'(p);
                        ien = e[0]; ipl = 3'(l);
                        step(p == 0 ? "R3 zero prio" : "R2 R8 R9 gate");
                        idle();
                    end

        // R4: several lines, ties, random patterns
        for (int k = 0; k < 400; k++) begin
            rng  = next_rng(rng); req = rng[NSRC-1:0];
            rng  = next_rng(rng); prio[31:0] = rng;
            rng  = next_rng(rng); prio[NSRC*3-1:32] = rng[NSRC*3-33:0];
            ipl  = 3'(k % 4); ien = 1; base = rng[31:12];
            step("R4 arbitration");
            idle();
        end
        // R4: explicit tie, lines 9 and 4 both at 6, line 4 wins
        req = '0; prio = '0; ipl = 0; ien = 1; base = 20'h00100;
        req[9] = 1; prio[27 +: 3] = 3'd6; req[4] = 1; prio[12 +: 3] = 3'd6;
        step("R4 tie");
        idle();

        // R5 R7: software beats an eligible maskable line, any enable
        for (int n = 0; n < 64; n++)
            for (int e = 0; e < 2; e++) begin
                req = '0; prio = '0; req[2] = 1; prio[6 +: 3] = 3'd7;
                ipl = 3'd0; ien = e[0]; stk = 1; base = 20'h0F000;
                sw_req = 1; sw_num = 6'(n);
                step("R5 R7 software");
                idle();
            end

        // R9: vector wraps at 20 bits
        base = 20'hFFFF0; sw_req = 1; sw_num = 6'd63; req = '0;
        step("R9 wrap");
        idle();

        // R10 R11: held request gives take, pause, take
        req = '0; prio = '0; req[7] = 1; prio[21 +: 3] = 3'd4;
        ien = 1; ipl = 3'd1; stk = 1; base = 20'h00400;
        #1;
        tests++;
        if (take_o !== 1'b0) begin
            fails++;
            $display("FAIL R11: got take=%0b before edge, exp 0", take_o);
        end
        step("R10 first");
        step("R10 locked");
        step("R10 again");
        idle();
        finish_run();
    end

endmodule